// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block turns a three-level PWM command into a registered drive command for a half-bridge gate driver. The analog PWM pin is compared against two thresholds outside this block. Each comparator has its own built-in hysteresis, so the rising and falling trip points of the mid window are distinct. This block receives two digital flags: one set when the pin is above the upper threshold, and one set when it is below the lower threshold. When neither flag is set, the pin is inside the mid window.

A pin held above the upper threshold commands the high-side switch on. A pin held below the lower threshold commands the low-side switch on. A pin that stays inside the mid window for a programmable hold-off period commands both switches off (TRISTATE). A short trip through the window, such as a slow edge passing between the thresholds, is filtered out and the current command continues. Leaving the window takes effect at once, with no hold-off.

Both flags are synchronized before use. A sample with both flags set cannot come from a real pin. Such a sample keeps the last command and marks the output as not valid for that cycle.

Top module: `tri_pwm_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cmd` becomes TRISTATE (2'b10) and `cmd_valid` becomes 0, whatever the comparator inputs are.
- R2: With `cmp_above_hi`=1 and `cmp_below_lo`=0, `cmd` becomes HIGH (2'b01) at the third rising clock edge after the inputs change (two synchronizer stages plus the command register).
- R3: With `cmp_below_lo`=1 and `cmp_above_hi`=0, `cmd` becomes LOW (2'b00) at the third rising clock edge after the inputs change.
- R4: If both inputs are 0 for fewer than HOLDOFF_CYC consecutive clock cycles, `cmd` keeps its previous HIGH or LOW value throughout.
- R5: If both inputs are 0 for HOLDOFF_CYC consecutive cycles, `cmd` becomes TRISTATE at rising edge HOLDOFF_CYC+2 after the inputs change, and not earlier.
- R6: Leaving TRISTATE to HIGH or to LOW takes the same three-edge latency as R2 and R3, with no hold-off added.
- R7: Any cycle in which either input is 1 restarts the hold-off count. Two mid-window stretches of HOLDOFF_CYC-1 cycles each, separated by one HIGH cycle, never produce TRISTATE.
- R8: With both inputs at 1, `cmd` keeps its last value and `cmd_valid` becomes 0, with the three-edge latency.
- R9: `cmd_valid` is 1 whenever the synchronized sample behind the current command is a legal combination: high, low or mid window.
- R10: `cmd` never takes the unused code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_above_hi | input | 1 | Asynchronous flag: PWM pin above the upper threshold |
| cmp_below_lo | input | 1 | Asynchronous flag: PWM pin below the lower threshold |
| cmd | output | 2 | Registered command: 2'b00 LOW, 2'b01 HIGH, 2'b10 TRISTATE |
| cmd_valid | output | 1 | Registered flag: the last synchronized sample was a legal combination |

## Verification
The assertions observe the synchronized zone rather than the raw pins. They therefore assume only that each flag is steady long enough to pass through the synchronizer, so a zone seen after the second stage is followed by the command register one edge later. The stimulus changes the inputs only at falling clock edges and holds each level for whole cycles. It sweeps every mid-window length from one cycle up to two cycles past the hold-off. Each sweep starts from both HIGH and LOW and exits to HIGH, LOW and the illegal both-set case. Every expected value follows from edge counting alone.

// File: rtl/tpd_pkg.sv
// Package: shared encodings for the three-level PWM decoder.
// Assumes: the command codes are decoded by the gate-driver stage downstream.
package tpd_pkg;

    // Drive command handed to the gate-driver stage
    typedef enum logic [1:0] {
        CMD_LOW  = 2'b00,
        CMD_HIGH = 2'b01,
        CMD_TRI  = 2'b10
    } cmd_e;

    // Where the synchronized pin sample lies relative to the thresholds
    typedef enum logic [1:0] {
        ZN_MID   = 2'b00,
        ZN_HIGH  = 2'b01,
        ZN_LOW   = 2'b10,
        ZN_CLASH = 2'b11
    } zone_e;

endpackage

// File: rtl/tpd_sync.sv
// Module: tpd_sync
// Multi-stage flop synchronizer for a bundle of asynchronous single-bit flags.
// Assumes: each bit is independent (no multi-bit coherency is needed) and
// STAGES >= 1. The reset value of every stage is 0.
module tpd_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // First stage: capture the raw asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    // Remaining stages: shift toward the output
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/tpd_zone.sv
// Module: tpd_zone
// Maps the two synchronized comparator flags to a zone code.
// Assumes: the flags are already synchronized; purely combinational.
module tpd_zone
    import tpd_pkg::*;
(
    input  logic  above_hi,
    input  logic  below_lo,
    output zone_e zone
);

    // Classify the sample; both flags set is physically impossible
    always_comb begin
        unique case ({below_lo, above_hi})
            2'b01:   zone = ZN_HIGH;
            2'b10:   zone = ZN_LOW;
            2'b11:   zone = ZN_CLASH;
            default: zone = ZN_MID;
        endcase
    end

endmodule

// File: rtl/tpd_holdoff.sv
// Module: tpd_holdoff
// Counts consecutive in-window cycles and flags when the hold-off is met.
// Assumes: HOLDOFF_CYC >= 1. The count restarts on any cycle outside the
// window and saturates, so a window held indefinitely keeps expire high.
module tpd_holdoff #(
    parameter int HOLDOFF_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_window,
    output logic expire
);

    localparam int CNT_W = (HOLDOFF_CYC > 1) ? $clog2(HOLDOFF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLDOFF_CYC - 1);

    logic [CNT_W-1:0] run_q;

    // Saturating count of in-window cycles already seen
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (!in_window)   run_q <= '0;
        else if (run_q < LAST) run_q <= run_q + 1'b1;
    end

    // This in-window cycle completes the hold-off
    assign expire = in_window && (run_q >= LAST);

endmodule

// File: rtl/tri_pwm_decoder.sv
// Module: tri_pwm_decoder (top)
// Decodes a three-level PWM command from two comparator flags into a
// registered HIGH / LOW / TRISTATE command and a validity flag.
// Assumes: the comparator flags are asynchronous to clk and carry their own
// analog hysteresis; HOLDOFF_CYC is the hold-off in clk cycles.
module tri_pwm_decoder
    import tpd_pkg::*;
#(
    parameter int HOLDOFF_CYC = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_above_hi,
    input  logic       cmp_below_lo,
    output logic [1:0] cmd,
    output logic       cmd_valid
);

    logic [1:0] flags_s;
    zone_e      zone_w;
    logic       expire_w;
    cmd_e       cmd_q;
    logic       valid_q;

    tpd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmp_below_lo, cmp_above_hi}),
        .q     (flags_s)
    );

    tpd_zone u_zone (
        .above_hi (flags_s[0]),
        .below_lo (flags_s[1]),
        .zone     (zone_w)
    );

    tpd_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_window (zone_w == ZN_MID),
        .expire    (expire_w)
    );

    // Command register: follow high/low at once, enter tristate only on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_TRI;
            valid_q <= 1'b0;
        end else begin
            unique case (zone_w)
                ZN_HIGH: cmd_q <= CMD_HIGH;
                ZN_LOW:  cmd_q <= CMD_LOW;
                ZN_MID:  if (expire_w) cmd_q <= CMD_TRI;
                default: cmd_q <= cmd_q;
            endcase
            valid_q <= (zone_w != ZN_CLASH);
        end
    end

    assign cmd       = cmd_q;
    assign cmd_valid = valid_q;

endmodule

// File: rtl/tpd_checker.sv
// Module: tpd_checker
// Property checker bound to tri_pwm_decoder. It watches the synchronized
// zone and keeps its own count of mid-window cycles.
// Assumes: zone is the decoded sample that feeds the command register.
module tpd_checker #(
    parameter int HOLDOFF_CYC = 18
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] zone,
    input logic [1:0] cmd,
    input logic       valid
);

    localparam int RW = $clog2(HOLDOFF_CYC + 1);

    logic [RW-1:0] mid_run;

    // Independent saturating run length of the mid zone
    always_ff @(posedge clk) begin
        if (!rst_n)                         mid_run <= '0;
        else if (zone != 2'b00)             mid_run <= '0;
        else if (int'(mid_run) < HOLDOFF_CYC) mid_run <= mid_run + 1'b1;
    end

    // R10
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'b11);

    // R2
    follow_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zone == 2'b01 |=> (cmd == 2'b01) && valid);

    // R3
    follow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zone == 2'b10 |=> (cmd == 2'b00) && valid);

    // R8
    clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zone == 2'b11 |=> $stable(cmd) && !valid);

    // R4
    short_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone == 2'b00) && (int'(mid_run) + 1 < HOLDOFF_CYC) |=> $stable(cmd) && valid);

    // R5
    long_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone == 2'b00) && (int'(mid_run) + 1 >= HOLDOFF_CYC) |=> cmd == 2'b10);

endmodule

bind tri_pwm_decoder tpd_checker #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .zone  (zone_w),
    .cmd   (cmd),
    .valid (cmd_valid)
);

// File: tb/tri_pwm_decoder_tb.sv
// Bench for tri_pwm_decoder: sweeps every mid-window length around a small
// hold-off, from both driven levels and into every exit level.
module tri_pwm_decoder_tb;

    localparam int H = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi = 1'b0;
    logic       lo = 1'b0;
    logic [1:0] cmd;
    logic       cmd_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    tri_pwm_decoder #(.HOLDOFF_CYC(H), .SYNC_STAGES(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_above_hi (hi),
        .cmp_below_lo (lo),
        .cmd          (cmd),
        .cmd_valid    (cmd_valid)
    );

    always #10 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic h, input logic l);
        hi = h;
        lo = l;
    endtask

    task automatic check(input string req, input logic [1:0] exp_cmd, input logic exp_valid);
        n_chk++;
        if (cmd !== exp_cmd || cmd_valid !== exp_valid || cmd === 2'b11) begin
            n_fail++;
            $display("FAIL %s: cmd=%b valid=%b expected cmd=%b valid=%b",
                     req, cmd, cmd_valid, exp_cmd, exp_valid);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            report();
        end
    end

    initial begin
        // R1: reset overrides an input that would command HIGH
        drive(1, 0);
        step(4);
        check("R1", 2'b10, 1'b0);
        drive(0, 0);
        step(1);
        rst_n = 1'b1;
        step(H + 3);
        check("R1", 2'b10, 1'b1);

        // R6 and R2: leave tristate to HIGH with three-edge latency
        drive(1, 0);
        step(2);
        check("R6", 2'b10, 1'b1);
        step(1);
        check("R2", 2'b01, 1'b1);

        // R5: tristate exactly at edge H+2
        drive(0, 0);
        step(H + 1);
        check("R4", 2'b01, 1'b1);
        step(1);
        check("R5", 2'b10, 1'b1);

        // R6 and R3: leave tristate to LOW
        drive(0, 1);
        step(2);
        check("R6", 2'b10, 1'b1);
        step(1);
        check("R3", 2'b00, 1'b1);

        // R7: one HIGH cycle splits two short windows; tristate never appears
        drive(1, 0);
        step(4);
        drive(0, 0);
        step(H - 1);
        drive(1, 0);
        step(1);
        drive(0, 0);
        for (int k = 0; k < H - 1; k++) begin
            step(1);
            check("R7", 2'b01, 1'b1);
        end
        drive(1, 0);
        for (int k = 0; k < 4; k++) begin
            step(1);
            check("R7", 2'b01, 1'b1);
        end

        // Sweep: start level, mid-window length, exit level
        for (int s = 0; s < 2; s++) begin
            for (int d = 1; d <= H + 2; d++) begin
                for (int x = 0; x < 3; x++) begin
                    logic [1:0] st;
                    logic [1:0] mid_exp;
                    st = (s == 0) ? 2'b01 : 2'b00;
                    if (s == 0) drive(1, 0); else drive(0, 1);
                    step(4);
                    check(s == 0 ? "R2" : "R3", st, 1'b1);
                    drive(0, 0);
                    step(d);
                    if (x == 0)      drive(1, 0);
                    else if (x == 1) drive(0, 1);
                    else             drive(1, 1);
                    step(2);
                    mid_exp = (d >= H) ? 2'b10 : st;
                    check(d >= H ? "R5" : "R4", mid_exp, 1'b1);
                    step(1);
                    if (x == 0)      check("R6", 2'b01, 1'b1);
                    else if (x == 1) check("R6", 2'b00, 1'b1);
                    else             check("R8", mid_exp, 1'b0);
                end
            end
        end

        // R9: validity returns once the sample is legal again
        drive(0, 1);
        step(3);
        check("R9", 2'b00, 1'b1);

        done = 1'b1;
        report();
    end

endmodule